// File: doc/BRIEF.md
# Two-Press Instruction Word Loader

This block builds a 12-bit instruction word and its 4-bit opcode from an 8-bit data bus. A single pushbutton acts as the load strobe, so the word arrives in two separate presses. The raw button level passes through a two-flop synchronizer. A rising-edge detector then turns each press into one capture strobe, however long the button is held.

A phase flag tracks which half comes next, and the strobes alternate between two capture phases:

- **First phase:** takes the opcode and the low nibble of the instruction field.
- **Second phase:** takes the upper byte, returns the flag to the first phase, and raises a one-cycle ready pulse for the controller that runs the instruction.

While the controller drives `busy` high, detected edges are dropped. A press made during execution cannot corrupt the word in flight.

Taken together, `{instr, opcode}` forms a 16-bit instruction word.

- **Register-register form:** the second register address sits in bits [10:7] and bits [15:11] are spare.
- **Immediate form:** the immediate is bits [15:8] and bit 7 is spare.
- **Both forms:** the opcode sits in bits [3:0] and the first register address in bits [6:4].

Top module: `insn_two_press_loader`

## Requirements
- R1: Synchronous reset, active low. Sampled low at a clock edge, it clears `opcode`, `instr`, `half_loaded` and `ready`. The next accepted press is then a first-phase press.
- R2: Only a rising edge of `btn_raw` triggers a capture. The edge is seen after two synchronizer flops. The outputs change at the third rising clock edge after `btn_raw` is first sampled high, and not before. Holding the button causes no further capture, even if `data_in` changes.
- R3: A first-phase capture does four things:
  - it loads `data_in[3:0]` into `opcode`;
  - it loads `data_in[7:4]` into `instr[3:0]`;
  - it leaves `instr[11:4]` unchanged;
  - it sets `half_loaded` to 1.
- R4: A second-phase capture does three things:
  - it loads `data_in[7:0]` into `instr[11:4]`;
  - it leaves `opcode` and `instr[3:0]` unchanged;
  - it clears `half_loaded`.
- R5: `ready` is high for exactly one cycle, in the cycle where the second-phase capture first shows on `instr`. A first-phase capture never raises it.
- R6: A button edge detected while `busy` is high is discarded. It does not change `opcode`, `instr` or `half_loaded`, and it does not raise `ready`.
- R7: Accepted presses alternate between the phases without end. The press after a completed second phase is a first-phase press.
- R8: After a second-phase capture, the 16-bit word `{instr, opcode}` holds the second-press byte in bits [15:8] and the first-press byte in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | Instruction byte bus |
| btn_raw | input | 1 | Unsynchronized load button level |
| busy | input | 1 | Controller busy; edges are dropped while high |
| opcode | output | 4 | Captured opcode |
| instr | output | 12 | Captured instruction field |
| half_loaded | output | 1 | High between the first and second capture |
| ready | output | 1 | One-cycle complete-word pulse |

## Verification
All 256 first-press bytes are swept, each paired with a second byte computed from it. This catches swapped or shifted nibbles, and any bit that is not driven into its field.

Each press is also sampled one cycle before its expected capture. This tells a correctly synchronized edge apart from a path that is too short. Changing `data_in` while the button is held separates edge-triggered capture from level-triggered capture.

A press made while `busy` is high, and a reset applied in the middle of a word, show whether the phase flag holds its state or advances wrongly.

// File: rtl/insn_loader_pkg.sv
package insn_loader_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign chain_d[g] = d;
    end else begin : g_rest
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;

  // A held level yields a single strobe
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/word_capture.sv
module word_capture
  import insn_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           strobe,
  input  logic [DATA_W-1:0]              data,
  output logic [OPC_W-1:0]               opcode,
  output logic [2*DATA_W-OPC_W-1:0]      instr,
  output logic                           half_loaded,
  output logic                           ready
);
  localparam int HI_W    = DATA_W - OPC_W;
  localparam int INSTR_W = HI_W + DATA_W;

  phase_e             phase_q, phase_d;
  logic [OPC_W-1:0]   opc_q, opc_d;
  logic [INSTR_W-1:0] ins_q, ins_d;
  logic               rdy_q, rdy_d;

  always_comb begin
    phase_d = phase_q;
    opc_d   = opc_q;
    ins_d   = ins_q;
    rdy_d   = 1'b0;
    if (strobe) begin
      if (phase_q == PH_FIRST) begin
        opc_d             = data[OPC_W-1:0];
        ins_d[HI_W-1:0]   = data[DATA_W-1:OPC_W];
        phase_d           = PH_SECOND;
      end else begin
        ins_d[INSTR_W-1:HI_W] = data;
        phase_d               = PH_FIRST;
        rdy_d                 = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      opc_q   <= '0;
      ins_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (strobe) begin
        phase_q <= phase_d;
        opc_q   <= opc_d;
        ins_q   <= ins_d;
      end
    end
  end

  assign opcode      = opc_q;
  assign instr       = ins_q;
  assign half_loaded = (phase_q == PH_SECOND);
  assign ready       = rdy_q;

  assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && phase_q == PH_FIRST) |=>
      (phase_q == PH_SECOND && opc_q == $past(data[OPC_W-1:0]) &&
       ins_q[HI_W-1:0] == $past(data[DATA_W-1:OPC_W]) &&
       $stable(ins_q[INSTR_W-1:HI_W]) && !rdy_q));

  assert_second_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && phase_q == PH_SECOND) |=>
      (phase_q == PH_FIRST && ins_q[INSTR_W-1:HI_W] == $past(data) &&
       $stable(opc_q) && $stable(ins_q[HI_W-1:0]) && rdy_q));

  assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(opc_q) && $stable(ins_q) && $stable(phase_q) && !rdy_q));
endmodule

// File: rtl/insn_two_press_loader.sv
module insn_two_press_loader #(
  parameter int DATA_W      = 8,
  parameter int OPC_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         data_in,
  input  logic                      btn_raw,
  input  logic                      busy,
  output logic [OPC_W-1:0]          opcode,
  output logic [2*DATA_W-OPC_W-1:0] instr,
  output logic                      half_loaded,
  output logic                      ready
);
  logic btn_s;
  logic btn_rise;
  logic take;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (btn_raw),
    .q     (btn_s)
  );

  rise_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (btn_s),
    .rise  (btn_rise)
  );

  assign take = btn_rise & ~busy;

  word_capture #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (take),
    .data        (data_in),
    .opcode      (opcode),
    .instr       (instr),
    .half_loaded (half_loaded),
    .ready       (ready)
  );

  assert_busy_drops_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_rise && busy) |=>
      ($stable(opcode) && $stable(instr) && $stable(half_loaded) && !ready));

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_ready_closes_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !half_loaded);
endmodule

// File: tb/test_insn_two_press_loader.sv
module test_insn_two_press_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  data_in;
  logic        btn_raw;
  logic        busy;
  logic [3:0]  opcode;
  logic [11:0] instr;
  logic        half_loaded;
  logic        ready;

  int tests = 0;
  int fails = 0;

  logic [3:0]  m_op;
  logic [11:0] m_instr;
  logic        m_half;

  always #2 clk = ~clk;

  insn_two_press_loader i_insn_two_press_loader (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .btn_raw(btn_raw), .busy(busy),
    .opcode(opcode), .instr(instr), .half_loaded(half_loaded), .ready(ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " opcode"}, {12'h0, opcode}, {12'h0, m_op});
    chk({req, " instr"},  {4'h0, instr},   {4'h0, m_instr});
    chk({req, " half"},   {15'h0, half_loaded}, {15'h0, m_half});
  endtask

  task automatic press(input logic [7:0] d, input logic blk);
    logic  exp_rdy;
    string tag;
    @(negedge clk);
    data_in = d; busy = blk; btn_raw = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_state("R2 latency");
    @(posedge clk);
    @(negedge clk);
    exp_rdy = 1'b0;
    if (blk) begin
      tag = "R6";
    end else if (!m_half) begin
      tag = "R3";
      m_op = d[3:0]; m_instr[3:0] = d[7:4]; m_half = 1'b1;
    end else begin
      tag = "R4";
      m_instr[11:4] = d; m_half = 1'b0; exp_rdy = 1'b1;
    end
    chk_state(tag);
    chk("R5 ready pulse", {15'h0, ready}, {15'h0, exp_rdy});
    @(negedge clk);
    data_in = ~d;
    chk("R5 ready drop", {15'h0, ready}, 16'h0);
    repeat (4) @(negedge clk);
    chk_state("R2 held");
    chk("R2 held ready", {15'h0, ready}, 16'h0);
    btn_raw = 1'b0; busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; btn_raw = 1'b0; busy = 1'b0; data_in = 8'h00;
    m_op = '0; m_instr = '0; m_half = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1 reset");
    chk("R1 ready", {15'h0, ready}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R4/R7/R8 sweep over every first-press byte
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b2;
      b2 = 8'((i * 37 + 11) ^ 8'hA5);
      press(8'(i), 1'b0);
      press(b2, 1'b0);
      chk("R8 word", {instr, opcode}, {b2, 8'(i)});
      chk("R7 phase", {15'h0, half_loaded}, 16'h0);
    end

    // R6: busy during first and second phase
    press(8'h3C, 1'b1);
    chk("R6 phase kept", {15'h0, half_loaded}, 16'h0);
    press(8'h73, 1'b0);
    press(8'hE1, 1'b1);
    chk("R6 phase kept mid", {15'h0, half_loaded}, 16'h1);
    press(8'h2D, 1'b0);
    chk("R8 word after busy", {instr, opcode}, 16'h2D73);

    // R1: reset in the middle of a word
    press(8'h95, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_op = '0; m_instr = '0; m_half = 1'b0;
    chk_state("R1 mid-word reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    press(8'h4B, 1'b0);
    chk("R1 first phase after reset", {12'h0, opcode}, 16'h000B);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule